// File: doc/BRIEF.md
# Stereo DAC Channel Routing Controller

This block sits between a stereo sample interface and a DAC datapath. Each time the sample-valid strobe is high, it takes one signed left sample and one signed right sample. It then produces one routed left sample and one routed right sample, together with an output strobe one clock later. A 4-bit routing field picks the source of each output. The source can be silence, the left input, the right input, or the mean of the two inputs.

A single control word holds the routing field, a power-down flag and an attenuation-sharing flag. It is written through a small address/data write port at address 2. While power-down is set, both outputs sit at mid-scale (code 0) and the held samples are dropped. The control word itself is kept. When power-down is released, a fixed run of incoming samples is thrown away before routed data appears again. The attenuation-sharing flag tells the downstream datapath to apply the left gain to the right channel. The new flag value takes effect from the next sample onward.

Top module: `dac_route_ctrl`

## Requirements
- R1: After reset, the routing field is 1001 (left output from the left input, right output from the right input). Power-down and attenuation sharing are both 0. Both outputs, `out_valid` and `att_share` are 0.
- R2: Only a write with `ctrl_addr` = 7'b0000010 changes the control word. In that word, bit 2 is power-down, bit 3 is attenuation sharing and bits 8:5 are the routing field. Writes to any other address have no effect.
- R3: Routing field bits 6:5 choose the left output's source and bits 8:7 choose the right output's source. The codes are 00 mute (0), 01 left input, 10 right input, 11 mean.
- R4: The mean is floor((L+R)/2), computed one bit wider than the samples, so it never overflows. For example, 0x7FFFFF and 0x7FFFFF give 0x7FFFFF, and 3 and -4 give -1.
- R5: `out_valid` is high exactly one clock after each `in_valid` cycle. The output data are registered in that same clock edge.
- R6: From the clock after a write that sets power-down, both outputs read 0 and stay 0 whatever the inputs do.
- R7: The routing field and the attenuation-sharing flag are kept across a power-down period.
- R8: After power-down is cleared, the outputs of the first 16 input strobes are 0. The 17th strobe produces routed data.
- R9: Setting power-down again before the 16 discards have finished restarts the full count of 16 discards.
- R10: `att_share` takes the value of the attenuation-sharing flag only on an input strobe. A write between strobes leaves `att_share` unchanged until the next strobe.
- R11: A routing change written between strobes leaves the outputs unchanged until the next strobe. That strobe is routed with the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write enable |
| ctrl_addr | input | 7 | Control write address |
| ctrl_data | input | 9 | Control write data |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Routed left sample |
| out_right | output | 24 | Routed right sample |
| att_share | output | 1 | Right channel uses the left attenuation |

## Verification
The two functions that can land in the same cycle are the wake-up discard count and a fresh power-down request. They are provoked by releasing power-down, feeding a few strobes, and then writing power-down again while the count is still partway through. The result is judged on the outputs: after the second release, exactly 16 zero samples must come out, followed by routed data. A second collision is a routing or sharing write between two strobes. For that case, the outputs and `att_share` are sampled before the next strobe, where they must still show the old state, and again after it.

// File: rtl/dac_route_pkg.sv
// Package: shared types and helpers for the DAC routing controller.
// Assumes the two's complement sample format and the 2-bit source codes
// used by every routing lane.
package dac_route_pkg;

    // Source selection code for one output lane.
    typedef enum logic [1:0] {
        SRC_MUTE  = 2'b00,
        SRC_LEFT  = 2'b01,
        SRC_RIGHT = 2'b10,
        SRC_MEAN  = 2'b11
    } src_sel_e;

    // Decoded control word fields.
    typedef struct packed {
        logic [3:0] route;
        logic       share;
        logic       pdown;
    } ctrl_fields_t;

    // Bit positions inside the written control word.
    localparam int PDOWN_BIT  = 2;
    localparam int SHARE_BIT  = 3;
    localparam int ROUTE_LSB  = 5;
    localparam int ROUTE_W    = 4;

    // Reset value of the routing field: left->left, right->right.
    localparam logic [3:0] ROUTE_RESET = 4'b1001;

endpackage

// File: rtl/dac_ctrl_regs.sv
// Module: dac_ctrl_regs
// Holds the control word (power-down, attenuation share, routing field).
// Assumes a single write port; only the matching address updates the word.
// Reset is synchronous and active-low and loads the default fields.
module dac_ctrl_regs
    import dac_route_pkg::*;
#(
    parameter int                 ADDR_W    = 7,
    parameter int                 DATA_W    = 9,
    parameter logic [ADDR_W-1:0]  WORD_ADDR = 7'b0000010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output ctrl_fields_t      fields
);

    localparam int ROUTE_MSB = ROUTE_LSB + ROUTE_W - 1;

    logic hit;

    // Address match for the single control word.
    always_comb begin
        hit = wr && (addr == WORD_ADDR);
    end

    // Control word storage, loaded on matching writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields.route <= ROUTE_RESET;
            fields.share <= 1'b0;
            fields.pdown <= 1'b0;
        end else if (hit) begin
            fields.route <= data[ROUTE_MSB:ROUTE_LSB];
            fields.share <= data[SHARE_BIT];
            fields.pdown <= data[PDOWN_BIT];
        end
    end

endmodule

// File: rtl/dac_wake_seq.sv
// Module: dac_wake_seq
// Counts discarded input strobes after power-down is released.
// Assumes the counter is reloaded every cycle power-down is high, so a
// reassertion part-way through restarts the full count.
module dac_wake_seq #(
    parameter int SKIP = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdown,
    input  logic in_valid,
    output logic busy
);

    localparam int CNT_W = $clog2(SKIP + 1);

    logic [CNT_W-1:0] remain;

    // Reload while powered down, count down one per strobe afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (pdown) begin
            remain <= CNT_W'(SKIP);
        end else if (in_valid && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    // Samples are discarded while powered down or while count remains.
    always_comb begin
        busy = pdown || (remain != '0);
    end

endmodule

// File: rtl/dac_route_lane.sv
// Module: dac_route_lane
// Combinational source selector for one output lane: mute, left, right
// or floor((L+R)/2). Assumes two's complement samples; the sum carries
// one guard bit, so the mean cannot overflow.
module dac_route_lane
    import dac_route_pkg::*;
#(
    parameter int DW = 24
) (
    input  src_sel_e              sel,
    input  logic signed [DW-1:0]  l,
    input  logic signed [DW-1:0]  r,
    output logic signed [DW-1:0]  y
);

    logic signed [DW:0] sum;

    // Widened sum; dropping its LSB is an arithmetic shift right by one.
    always_comb begin
        sum = {l[DW-1], l} + {r[DW-1], r};
    end

    // Source multiplexer.
    always_comb begin
        unique case (sel)
            SRC_MUTE:  y = '0;
            SRC_LEFT:  y = l;
            SRC_RIGHT: y = r;
            SRC_MEAN:  y = sum[DW:1];
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/dac_route_ctrl.sv
// Module: dac_route_ctrl (top)
// Routes stereo samples to two DAC lanes under a control word, handles
// power-down with mid-scale (0) outputs and a post-wake discard run, and
// registers the attenuation-share flag on each input strobe.
// Assumes one sample pair per in_valid cycle; outputs update one clock later.
module dac_route_ctrl
    import dac_route_pkg::*;
#(
    parameter int                 DW        = 24,
    parameter int                 ADDR_W    = 7,
    parameter int                 CTRL_W    = 9,
    parameter logic [ADDR_W-1:0]  WORD_ADDR = 7'b0000010,
    parameter int                 SKIP      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [ADDR_W-1:0]    ctrl_addr,
    input  logic [CTRL_W-1:0]    ctrl_data,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right,
    output logic                 att_share
);

    localparam int LANES = 2;

    ctrl_fields_t          fields;
    logic                  wake_busy;
    logic signed [DW-1:0]  lane_y [LANES];
    logic signed [DW-1:0]  lane_q [LANES];
    logic                  valid_q;
    logic                  share_q;

    dac_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (CTRL_W),
        .WORD_ADDR (WORD_ADDR)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctrl_wr),
        .addr   (ctrl_addr),
        .data   (ctrl_data),
        .fields (fields)
    );

    dac_wake_seq #(
        .SKIP (SKIP)
    ) wake_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdown    (fields.pdown),
        .in_valid (in_valid),
        .busy     (wake_busy)
    );

    // One selector and one output register per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dac_route_lane #(
            .DW (DW)
        ) lane_i (
            .sel (src_sel_e'(fields.route[2*g +: 2])),
            .l   (in_left),
            .r   (in_right),
            .y   (lane_y[g])
        );

        // Capture the routed sample on a strobe; clear history when down.
        always_ff @(posedge clk) begin
            if (!rst_n || fields.pdown) begin
                lane_q[g] <= '0;
            end else if (in_valid) begin
                lane_q[g] <= wake_busy ? '0 : lane_y[g];
            end
        end
    end

    // Output strobe trails the input strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
        end
    end

    // Attenuation-share flag follows the register only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            share_q <= 1'b0;
        end else if (in_valid) begin
            share_q <= fields.share;
        end
    end

    // Drive ports; power-down forces mid-scale at once.
    always_comb begin
        out_valid = valid_q;
        att_share = share_q;
        out_left  = fields.pdown ? '0 : lane_q[0];
        out_right = fields.pdown ? '0 : lane_q[1];
    end

endmodule

// File: rtl/dac_route_ctrl_chk.sv
// Module: dac_route_ctrl_chk
// Assertion checker bound to dac_route_ctrl; observes ports plus the
// decoded power-down flag and the wake sequencer's busy flag.
module dac_route_ctrl_chk #(
    parameter int DW     = 24,
    parameter int ADDR_W = 7,
    parameter int CTRL_W = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_wr,
    input logic [ADDR_W-1:0]    ctrl_addr,
    input logic [CTRL_W-1:0]    ctrl_data,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_left,
    input logic signed [DW-1:0] out_right,
    input logic                 att_share,
    input logic                 pdown,
    input logic                 wake_busy
);

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    pdown_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_addr == 7'b0000010 && ctrl_data[2])
        |=> (out_left == '0 && out_right == '0));

    // R8
    wake_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_busy |-> (out_left == '0 && out_right == '0));

    // R10
    share_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> $stable(att_share));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && !pdown && !$past(pdown))
        |-> ($stable(out_left) && $stable(out_right)));

endmodule

bind dac_route_ctrl dac_route_ctrl_chk #(
    .DW     (DW),
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_addr (ctrl_addr),
    .ctrl_data (ctrl_data),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .att_share (att_share),
    .pdown     (fields.pdown),
    .wake_busy (wake_busy)
);

// File: tb/dac_route_ctrl_tb.sv
// Directed bench for dac_route_ctrl: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// on the falling edge after the capturing rising edge.
module dac_route_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ctrl_wr = 1'b0;
    logic [6:0]           ctrl_addr = '0;
    logic [8:0]           ctrl_data = '0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_left = '0;
    logic signed [DW-1:0] in_right = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_left;
    logic signed [DW-1:0] out_right;
    logic                 att_share;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_route_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_addr (ctrl_addr),
        .ctrl_data (ctrl_data),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_right (out_right),
        .att_share (att_share)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] word(input logic pd, input logic sh,
                                        input logic [3:0] route);
        return {route, 1'b0, sh, pd, 2'b00};
    endfunction

    function automatic longint pick(input logic [1:0] c, input longint l,
                                    input longint r);
        case (c)
            2'b00:   return 0;
            2'b01:   return l;
            2'b10:   return r;
            default: return (l + r) >>> 1;
        endcase
    endfunction

    task automatic write(input logic [6:0] a, input logic [8:0] d);
        ctrl_wr = 1'b1; ctrl_addr = a; ctrl_data = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic send(input longint l, input longint r);
        in_valid = 1'b1; in_left = DW'(l); in_right = DW'(r);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_expect(input string tag, input longint l, input longint r,
                               input longint el, input longint er);
        send(l, r);
        check({tag, " out_valid"}, out_valid, 1);
        check({tag, " left"}, out_left, el);
        check({tag, " right"}, out_right, er);
    endtask

    task automatic t_reset();
        check("R1 reset left", out_left, 0);
        check("R1 reset right", out_right, 0);
        check("R1 reset valid", out_valid, 0);
        check("R1 reset share", att_share, 0);
        send_expect("R1 default route", 100, -200, 100, -200);
        @(negedge clk);
        check("R5 valid drops", out_valid, 0);
    endtask

    task automatic t_addr();
        write(7'b0000011, word(1'b1, 1'b1, 4'b0000));
        write(7'b1000010, word(1'b0, 1'b0, 4'b0000));
        send_expect("R2 other address ignored", 7, -9, 7, -9);
        check("R2 share untouched", att_share, 0);
    endtask

    task automatic t_routes();
        for (int c = 0; c < 16; c++) begin
            logic [3:0] code = 4'(c);
            write(7'b0000010, word(1'b0, 1'b0, code));
            send_expect($sformatf("R3 code %0d", c), 1000, -3000,
                        pick(code[1:0], 1000, -3000), pick(code[3:2], 1000, -3000));
        end
    endtask

    task automatic t_mean();
        write(7'b0000010, word(1'b0, 1'b0, 4'b1111));
        send_expect("R4 max", 8388607, 8388607, 8388607, 8388607);
        send_expect("R4 min", -8388608, -8388608, -8388608, -8388608);
        send_expect("R4 floor", 3, -4, -1, -1);
    endtask

    task automatic t_hold();
        write(7'b0000010, word(1'b0, 1'b0, 4'b1001));
        send_expect("R11 setup", 11, 22, 11, 22);
        write(7'b0000010, word(1'b0, 1'b1, 4'b0110));
        check("R11 left held", out_left, 11);
        check("R11 right held", out_right, 22);
        check("R10 share held", att_share, 0);
        send_expect("R11 new route", 33, 44, 44, 33);
        check("R10 share applied", att_share, 1);
    endtask

    task automatic t_pdown();
        write(7'b0000010, word(1'b1, 1'b1, 4'b0110));
        check("R6 immediate left", out_left, 0);
        check("R6 immediate right", out_right, 0);
        send_expect("R6 during down", 55, 66, 0, 0);
        write(7'b0000010, word(1'b0, 1'b1, 4'b0110));
        for (int i = 0; i < 16; i++) send_expect($sformatf("R8 discard %0d", i), 5, 6, 0, 0);
        send_expect("R8 first routed", 5, 6, 6, 5);
        check("R7 share kept", att_share, 1);
    endtask

    task automatic t_restart();
        write(7'b0000010, word(1'b1, 1'b0, 4'b1111));
        write(7'b0000010, word(1'b0, 1'b0, 4'b1111));
        for (int i = 0; i < 5; i++) send(8, 4);
        write(7'b0000010, word(1'b1, 1'b0, 4'b1111));
        write(7'b0000010, word(1'b0, 1'b0, 4'b1111));
        for (int i = 0; i < 16; i++) send_expect($sformatf("R9 discard %0d", i), 8, 4, 0, 0);
        send_expect("R9 routed after full count", 8, 4, 6, 6);
        check("R7 route kept", out_left, 6);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_routes();
        t_mean();
        t_hold();
        t_pdown();
        t_restart();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule